// File: doc/BRIEF.md
# Asynchronous Host Byte Loader Port

This block is the slave side of a byte-wide loading port on a programmable device. An external host selects the port with two chip selects of opposite polarity. It drives asynchronous write and read strobes and moves configuration bytes over an 8-bit bidirectional bus. Each written byte goes to an internal consumer through a valid/ready pair. The port tells the host through a ready line and through a status readback whether it can take another byte.

Around the byte path the block runs the start-up sequence:

- After reset it drives the open-drain hold line low while the device settles and clears its memory.
- It then waits for the host to let that line rise.
- It latches the four boot-mode inputs on that rise and enters the loading phase.
- When the consumer reports that loading is finished, it releases the two in-progress flag pins and moves to a user phase, where the host strobes have no effect.

All host-side inputs pass through a two-flop synchronizer before use. The bus is split into an input, an output and a per-bit output enable, which the pad ring combines.

Top module: `cfg_byte_port`

## Requirements
- R1: The port is selected only while `sel_lo_n` is 0 and `sel_hi` is 1. With any other combination, strobes capture nothing and `bus_oe` stays 8'h00.
- R2: While the port is selected in the loading phase, each falling edge of `wstrb_n` captures `bus_in` once. The byte appears on `byte_data` with `byte_valid` high.
- R3: `byte_valid` and `byte_data` hold until a cycle with `byte_ready` high. `host_ready` is low while a byte is pending and high again after the consumer takes it.
- R4: A write captured while a byte is still pending sets a sticky overrun flag, and that byte is dropped: `byte_data` keeps the earlier byte.
- R5: While the port is selected and `rstrb_n` is low, `bus_oe` is 8'hF8 and `bus_out[7:3]` = {host_ready, overrun, loaded_flag, boot_mode_q[1:0]}, with bits 2..0 undriven. `bus_oe` returns to 8'h00 within four cycles after `rstrb_n` rises.
- R6: When both strobes are low together, the write wins: the byte is captured and `bus_oe` stays 8'h00.
- R7: After reset, `hold_pull` is 1 for exactly CLEAR_CYCLES cycles and then 0 for good.
- R8: While the sensed hold line `hold_in` stays low after clearing, the port does not start loading: `host_ready` is 0 and writes capture nothing.
- R9: `boot_mode_q` takes `boot_mode` when `hold_in` rises after clearing and keeps that value through later changes of `boot_mode`.
- R10: `flag_oe` is 1 with `flag_hi`=1 and `flag_lo`=0 from reset until `load_done` is seen in the loading phase. After that `flag_oe` is 0.
- R11: After `load_done`, writes and reads have no effect: no capture, `host_ready` 0, `bus_oe` 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wstrb_n | input | 1 | Host write strobe, active low, asynchronous |
| rstrb_n | input | 1 | Host status-read strobe, active low, asynchronous |
| bus_in | input | 8 | Host data bus as seen at the pad |
| bus_out | output | 8 | Value driven onto the host bus |
| bus_oe | output | 8 | Per-bit output enable for the host bus |
| boot_mode | input | 4 | Boot-mode selection pins |
| hold_in | input | 1 | Sensed level of the open-drain hold line |
| hold_pull | output | 1 | Pulls the hold line low when 1 |
| host_ready | output | 1 | High when another byte may be written |
| flag_hi | output | 1 | In-progress flag, high while loading |
| flag_lo | output | 1 | In-progress flag, low while loading |
| flag_oe | output | 1 | Output enable of both in-progress flags |
| byte_data | output | 8 | Byte handed to the consumer |
| byte_valid | output | 1 | Byte on `byte_data` is pending |
| byte_ready | input | 1 | Consumer takes the pending byte |
| load_done | input | 1 | Consumer reports loading is finished |
| boot_mode_q | output | 4 | Latched boot mode |

## Verification
The hardest case to reach is a write that lands while the previous byte is still pending, together with the status readback that shows it. The bench holds `byte_ready` low across two full host write cycles. It then checks that the first byte survived, releases the consumer, and reads the status to see the overrun bit beside a restored ready bit. The write-over-read case is reached by lowering both strobes in the same cycle, so that they leave the synchronizer together.

// File: rtl/cfg_port_pkg.sv
// Package: shared types for the host byte loader port.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package cfg_port_pkg;

    // Phases of the loader, in the order they occur after reset.
    typedef enum logic [1:0] {
        PH_CLEAR = 2'd0,
        PH_WAIT  = 2'd1,
        PH_LOAD  = 2'd2,
        PH_USER  = 2'd3
    } cfg_phase_e;

    // Status word placed on the top bits of the host bus during a read.
    typedef struct packed {
        logic       ready;
        logic       overrun;
        logic       loaded;
        logic [1:0] mode_lo;
    } cfg_status_t;

    localparam int STATUS_W = $bits(cfg_status_t);

endpackage

// File: rtl/cfg_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; the reset value is the idle level of each bit.
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Sample the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Shift toward the synchronized output.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_seq.sv
// Module: start-up sequencer. Holds the hold line low while clearing, waits
// for the line to rise, latches the boot mode and tracks the loading phase.
// Assumes hold_s is already synchronized and that the pad is wired-AND with
// hold_pull, so the line reads low throughout clearing.
module cfg_seq
    import cfg_port_pkg::*;
#(
    parameter int CLEAR_CYCLES = 16,
    parameter int MODE_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_s,
    input  logic              load_done,
    input  logic [MODE_W-1:0] boot_mode,
    output cfg_phase_e        phase,
    output logic [MODE_W-1:0] mode_q,
    output logic              hold_pull,
    output logic              flags_on
);

    localparam int CNT_W = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLEAR_CYCLES - 1);

    logic [CNT_W-1:0] clr_cnt;

    // Phase advance and clearing timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CLEAR;
            clr_cnt <= '0;
        end else begin
            unique case (phase)
                PH_CLEAR: begin
                    if (clr_cnt == CNT_LAST) phase <= PH_WAIT;
                    else                     clr_cnt <= clr_cnt + 1'b1;
                end
                PH_WAIT:  if (hold_s)    phase <= PH_LOAD;
                PH_LOAD:  if (load_done) phase <= PH_USER;
                default:  phase <= PH_USER;
            endcase
        end
    end

    // Boot-mode latch, taken once when the hold line is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode_q <= '0;
        else if (phase == PH_WAIT && hold_s) mode_q <= boot_mode;
    end

    assign hold_pull = (phase == PH_CLEAR);
    assign flags_on  = (phase != PH_USER);

endmodule

// File: rtl/cfg_host_if.sv
// Module: host strobe decoder. Decodes the select pair, finds the write edge,
// gives the write priority over the read and builds the status drive.
// Assumes all strobe inputs are synchronized; the strobes are ignored in the user phase.
module cfg_host_if
    import cfg_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_phase_e        phase,
    input  logic              sel_lo_n_s,
    input  logic              sel_hi_s,
    input  logic              wstrb_n_s,
    input  logic              rstrb_n_s,
    input  cfg_status_t       status,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe
);

    localparam int LOW_W = DATA_W - STATUS_W;

    logic selected, live, wr_act, rd_act, wr_act_q;

    // Select decode and strobe qualification; write overrides read.
    always_comb begin
        selected = !sel_lo_n_s && sel_hi_s;
        live     = (phase != PH_USER);
        wr_act   = selected && live && !wstrb_n_s;
        rd_act   = selected && live && !rstrb_n_s && wstrb_n_s;
    end

    // Previous write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end

    assign wr_pulse = wr_act && !wr_act_q;
    assign bus_out  = rd_act ? {status, {LOW_W{1'b0}}} : '0;
    assign bus_oe   = {{STATUS_W{rd_act}}, {LOW_W{1'b0}}};

endmodule

// File: rtl/cfg_byte_buf.sv
// Module: one-entry holding register between the host and the consumer,
// with overrun detection and the host ready indication.
// Assumes the host holds bus data stable while its write strobe is low.
module cfg_byte_buf
    import cfg_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_phase_e        phase,
    input  logic              wr_pulse,
    input  logic [DATA_W-1:0] din,
    input  logic              byte_ready,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              overrun,
    output logic              host_ready
);

    // Capture, hand-off and overrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
            overrun    <= 1'b0;
        end else if (phase != PH_LOAD) begin
            byte_valid <= 1'b0;
        end else if (byte_valid) begin
            if (byte_ready) byte_valid <= 1'b0;
            if (wr_pulse)   overrun    <= 1'b1;
        end else if (wr_pulse) begin
            byte_valid <= 1'b1;
            byte_data  <= din;
        end
    end

    assign host_ready = (phase == PH_LOAD) && !byte_valid;

endmodule

// File: rtl/cfg_byte_port.sv
// Module: top of the host byte loader port. Synchronizes host inputs,
// sequences start-up, decodes strobes and buffers one byte for the consumer.
// Assumes the pad ring merges bus_out/bus_oe with bus_in, and hold_in with hold_pull.
module cfg_byte_port
    import cfg_port_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int MODE_W       = 4,
    parameter int CLEAR_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wstrb_n,
    input  logic              rstrb_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    input  logic [MODE_W-1:0] boot_mode,
    input  logic              hold_in,
    output logic              hold_pull,
    output logic              host_ready,
    output logic              flag_hi,
    output logic              flag_lo,
    output logic              flag_oe,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_valid,
    input  logic              byte_ready,
    input  logic              load_done,
    output logic [MODE_W-1:0] boot_mode_q
);

    localparam int            SYNC_W   = 5;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 5'b01101;

    cfg_phase_e        phase;
    logic [SYNC_W-1:0] sync_q;
    logic              sel_lo_n_s, sel_hi_s, wstrb_n_s, rstrb_n_s, hold_s;
    logic              wr_pulse, overrun, flags_on;
    cfg_status_t       status;

    cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hold_in, rstrb_n, wstrb_n, sel_hi, sel_lo_n}),
        .q     (sync_q)
    );

    assign {hold_s, rstrb_n_s, wstrb_n_s, sel_hi_s, sel_lo_n_s} = sync_q;

    cfg_seq #(.CLEAR_CYCLES(CLEAR_CYCLES), .MODE_W(MODE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_s    (hold_s),
        .load_done (load_done),
        .boot_mode (boot_mode),
        .phase     (phase),
        .mode_q    (boot_mode_q),
        .hold_pull (hold_pull),
        .flags_on  (flags_on)
    );

    // Status word seen by the host on a read.
    always_comb begin
        status.ready   = host_ready;
        status.overrun = overrun;
        status.loaded  = (phase == PH_LOAD) || (phase == PH_USER);
        status.mode_lo = boot_mode_q[1:0];
    end

    cfg_host_if #(.DATA_W(DATA_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .sel_lo_n_s (sel_lo_n_s),
        .sel_hi_s   (sel_hi_s),
        .wstrb_n_s  (wstrb_n_s),
        .rstrb_n_s  (rstrb_n_s),
        .status     (status),
        .wr_pulse   (wr_pulse),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe)
    );

    cfg_byte_buf #(.DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .wr_pulse   (wr_pulse),
        .din        (bus_in),
        .byte_ready (byte_ready),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .overrun    (overrun),
        .host_ready (host_ready)
    );

    assign flag_oe = flags_on;
    assign flag_hi = flags_on;
    assign flag_lo = !flags_on;

endmodule

// File: rtl/cfg_byte_port_checker.sv
// Module: temporal checks for cfg_byte_port, attached by bind.
// Assumes the default 8-bit bus with a 5-bit status field on the top bits.
module cfg_byte_port_checker
    import cfg_port_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cfg_phase_e phase,
    input logic [7:0] bus_oe,
    input logic       byte_valid,
    input logic       byte_ready,
    input logic [7:0] byte_data,
    input logic       host_ready,
    input logic       flag_oe,
    input logic       load_done,
    input logic [3:0] boot_mode_q,
    input logic       hold_pull
);

    assert_status_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe != 8'h00) |-> (bus_oe == 8'hF8 && phase != PH_USER));

    assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready && !load_done) |=> (byte_valid && $stable(byte_data)));

    assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !byte_valid);

    assert_user_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_USER) |-> (!host_ready && bus_oe == 8'h00 && !byte_valid));

    assert_flag_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_oe) |-> $past(load_done));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD && $past(phase) == PH_LOAD) |-> $stable(boot_mode_q));

    assert_clear_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLEAR) |-> hold_pull);

    assert_wait_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> (!byte_valid && !host_ready));

endmodule

bind cfg_byte_port cfg_byte_port_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .bus_oe      (bus_oe),
    .byte_valid  (byte_valid),
    .byte_ready  (byte_ready),
    .byte_data   (byte_data),
    .host_ready  (host_ready),
    .flag_oe     (flag_oe),
    .load_done   (load_done),
    .boot_mode_q (boot_mode_q),
    .hold_pull   (hold_pull)
);

// File: tb/cfg_byte_port_bench.sv
// Directed bench for cfg_byte_port; one task per scenario.
module cfg_byte_port_bench;

    localparam int CLR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_lo_n = 1'b1, sel_hi = 1'b0, wstrb_n = 1'b1, rstrb_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, bus_oe, byte_data;
    logic [3:0] boot_mode = 4'b0000, boot_mode_q;
    logic       host_hold = 1'b0;
    logic       hold_in, hold_pull, host_ready, flag_hi, flag_lo, flag_oe;
    logic       byte_valid, byte_ready = 1'b0, load_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    assign hold_in = hold_pull ? 1'b0 : host_hold;

    always #4 clk = ~clk;

    cfg_byte_port #(.CLEAR_CYCLES(CLR)) u_cfg_byte_port (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .wstrb_n(wstrb_n), .rstrb_n(rstrb_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .boot_mode(boot_mode), .hold_in(hold_in),
        .hold_pull(hold_pull), .host_ready(host_ready), .flag_hi(flag_hi),
        .flag_lo(flag_lo), .flag_oe(flag_oe), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .load_done(load_done),
        .boot_mode_q(boot_mode_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b, input logic lo_n, input logic hi);
        sel_lo_n = lo_n; sel_hi = hi; bus_in = b;
        cyc(1); wstrb_n = 1'b0; cyc(4); wstrb_n = 1'b1; cyc(4);
        sel_lo_n = 1'b1; sel_hi = 1'b0; cyc(2);
    endtask

    task automatic accept();
        byte_ready = 1'b1; cyc(1); byte_ready = 1'b0; cyc(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
        chk("R7 pull after reset", hold_pull, 1'b1);
        chk("R10 flags driven", {flag_oe, flag_hi, flag_lo}, 3'b110);
        chk("R8 not ready", host_ready, 1'b0);
        chk("R1 bus idle", bus_oe, 8'h00);
    endtask

    task automatic t_clear();
        cyc(CLR - 3);
        chk("R7 still pulling", hold_pull, 1'b1);
        cyc(4);
        chk("R7 released", hold_pull, 1'b0);
    endtask

    task automatic t_wait();
        host_write(8'h77, 1'b0, 1'b1);
        chk("R8 no capture in wait", byte_valid, 1'b0);
        chk("R8 not ready in wait", host_ready, 1'b0);
    endtask

    task automatic t_mode();
        boot_mode = 4'b1010; host_hold = 1'b1; cyc(6);
        chk("R9 mode latched", boot_mode_q, 4'b1010);
        chk("R3 ready in load", host_ready, 1'b1);
        boot_mode = 4'b0101; cyc(5);
        chk("R9 mode held", boot_mode_q, 4'b1010);
    endtask

    task automatic t_select();
        host_write(8'h12, 1'b1, 1'b1);
        chk("R1 lo_n high ignored", byte_valid, 1'b0);
        host_write(8'h34, 1'b0, 1'b0);
        chk("R1 hi low ignored", byte_valid, 1'b0);
        sel_lo_n = 1'b0; sel_hi = 1'b0; rstrb_n = 1'b0; cyc(4);
        chk("R1 read deselected", bus_oe, 8'h00);
        rstrb_n = 1'b1; sel_lo_n = 1'b1; cyc(4);
    endtask

    task automatic t_handshake();
        host_write(8'hA5, 1'b0, 1'b1);
        chk("R2 captured", {byte_valid, byte_data}, {1'b1, 8'hA5});
        chk("R3 busy", host_ready, 1'b0);
        cyc(5);
        chk("R3 held", {byte_valid, byte_data}, {1'b1, 8'hA5});
        accept();
        chk("R3 taken", {byte_valid, host_ready}, 2'b01);
    endtask

    task automatic t_overrun_status();
        host_write(8'h11, 1'b0, 1'b1);
        host_write(8'h22, 1'b0, 1'b1);
        chk("R4 first kept", {byte_valid, byte_data}, {1'b1, 8'h11});
        accept();
        chk("R4 second dropped", byte_valid, 1'b0);
        sel_lo_n = 1'b0; sel_hi = 1'b1; cyc(1); rstrb_n = 1'b0; cyc(4);
        chk("R5 status oe", bus_oe, 8'hF8);
        chk("R5 status word", bus_out, 8'hF0);
        rstrb_n = 1'b1; cyc(4);
        chk("R5 released", bus_oe, 8'h00);
        sel_lo_n = 1'b1; sel_hi = 1'b0; cyc(2);
    endtask

    task automatic t_priority();
        sel_lo_n = 1'b0; sel_hi = 1'b1; bus_in = 8'h3C; cyc(1);
        wstrb_n = 1'b0; rstrb_n = 1'b0; cyc(4);
        chk("R6 no drive", bus_oe, 8'h00);
        chk("R6 write taken", {byte_valid, byte_data}, {1'b1, 8'h3C});
        wstrb_n = 1'b1; rstrb_n = 1'b1; cyc(4);
        sel_lo_n = 1'b1; sel_hi = 1'b0; cyc(2);
        accept();
    endtask

    task automatic t_user();
        load_done = 1'b1; cyc(1); load_done = 1'b0; cyc(1);
        chk("R10 flags released", flag_oe, 1'b0);
        host_write(8'h5A, 1'b0, 1'b1);
        chk("R11 no capture", byte_valid, 1'b0);
        chk("R11 not ready", host_ready, 1'b0);
        sel_lo_n = 1'b0; sel_hi = 1'b1; rstrb_n = 1'b0; cyc(4);
        chk("R11 no status", bus_oe, 8'h00);
        rstrb_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b0; cyc(2);
    endtask

    initial begin
        t_reset();
        t_clear();
        t_wait();
        t_mode();
        t_select();
        t_handshake();
        t_overrun_status();
        t_priority();
        t_user();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule